// File: doc/BRIEF.md
# Prioritized Mixed-Trigger Interrupt Controller

This block gathers interrupt requests from a set of device lines and drives one interrupt output to a processor. Each line is set up on its own as either a live level request or a latched edge request. A level request follows the line and vanishes when the device drops it. An edge request is caught on a chosen transition (rising or falling) and kept in a sticky pending bit until software clears it.

Every line has an enable bit and a 4-bit priority. Among the enabled active requests, a combinational arbiter reports the winning source index and a valid flag. Software reads these as its query result and clears captured edges with an indexed clear strobe. When it handles the winner and clears it, the next query shows the next highest source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: With `cfg_edge[i]`=0 (level mode), source i is active while its synchronized line is 1, and it stops being active once the line returns to 0. Nothing is latched.
- R2: With `cfg_edge[i]`=1 (edge mode), one transition on the line sets a pending bit. That bit stays set after the line returns to its old value.
- R3: `cfg_falling[i]`=0 selects capture on a 0-to-1 transition. `cfg_falling[i]`=1 selects capture on a 1-to-0 transition. The other direction is not captured.
- R4: A pending bit is cleared only when `clr_valid`=1 and `clr_index` equals the source index. Activity on the line never clears it. If a new edge is detected in the same cycle as its clear, the bit stays set.
- R5: `irq_out` is 1 exactly when at least one enabled source is active.
- R6: `query_id` names the enabled active source with the largest priority value `cfg_prio[4*i+3:4*i]`. Once that source is withdrawn or cleared, the query names the next highest one.
- R7: When active sources tie on priority, the lowest index wins.
- R8: When no enabled source is active, `query_valid` is 0.
- R9: A source with `cfg_enable[i]`=0 neither drives `irq_out` nor appears in the query. An edge seen while it is disabled is still recorded, and it shows up once the source is enabled.
- R10: A line change reaches a level request after 2 rising clock edges and sets a pending bit on the 3rd. A clear takes effect on the next rising edge. The query and `irq_out` respond combinationally to the enable and priority settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_line | input | N_SRC | Device request lines, asynchronous |
| cfg_enable | input | N_SRC | Per-source enable |
| cfg_edge | input | N_SRC | 1 = edge mode, 0 = level mode |
| cfg_falling | input | N_SRC | Edge direction: 1 = falling, 0 = rising |
| cfg_prio | input | N_SRC*PRIO_W | Packed per-source priorities, source i at bits [PRIO_W*i +: PRIO_W] |
| clr_valid | input | 1 | Clear strobe for one pending bit |
| clr_index | input | ID_W | Source whose pending bit is cleared |
| irq_out | output | 1 | Interrupt request to the processor |
| query_valid | output | 1 | An enabled request is active |
| query_id | output | ID_W | Index of the winning source |

## Verification
If a pending bit is wrongly cleared or never set, the fault shows within one cycle. Either `irq_out` drops or the query moves to the wrong source, and it stays that way until the next edge. A fault in the synchronizer or the previous-value register shows up as a changed latency: a level request appears one cycle early or late, or an edge is missed or caught in the wrong direction. A fault in the arbiter shows at once in `query_id`, through tie order or priority order. The checks therefore sample on exact cycle counts after each line change and after each clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef struct packed {
        logic sync1;
        logic sync2;
        logic prev;
        logic pend;
    } src_state_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic edge_mode_i,
    input  logic falling_i,
    input  logic clr_i,
    output logic req_o
);
    src_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = line_i;
        st_d.sync2 = st_q.sync1;
        st_d.prev  = st_q.sync2;
        hit        = falling_i ? (!st_q.sync2 && st_q.prev)
                               : (st_q.sync2 && !st_q.prev);
        if (clr_i)
            st_d.pend = 1'b0;
        if (edge_mode_i && hit)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = edge_mode_i ? st_q.pend : st_q.sync2;

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> st_q.pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]        active_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output logic                    valid_o,
    output logic [ID_W-1:0]         id_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        valid_o = 1'b0;
        best_p  = '0;
        id_o    = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (active_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
                valid_o = 1'b1;
                best_p  = prio_i[i*PRIO_W +: PRIO_W];
                id_o    = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4,
    localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        irq_line,
    input  logic [N_SRC-1:0]        cfg_enable,
    input  logic [N_SRC-1:0]        cfg_edge,
    input  logic [N_SRC-1:0]        cfg_falling,
    input  logic [N_SRC*PRIO_W-1:0] cfg_prio,
    input  logic                    clr_valid,
    input  logic [ID_W-1:0]         clr_index,
    output logic                    irq_out,
    output logic                    query_valid,
    output logic [ID_W-1:0]         query_id
);
    logic [N_SRC-1:0] raw_req;
    logic [N_SRC-1:0] active;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .line_i      (irq_line[g]),
            .edge_mode_i (cfg_edge[g]),
            .falling_i   (cfg_falling[g]),
            .clr_i       (clr_valid && (clr_index == ID_W'(g))),
            .req_o       (raw_req[g])
        );
    end

    assign active  = raw_req & cfg_enable;
    assign irq_out = |active;

    irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .active_i (active),
        .prio_i   (cfg_prio),
        .valid_o  (query_valid),
        .id_o     (query_id)
    );

    // R5
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == query_valid);

    // R6
    win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        query_valid |-> active[query_id]);

    // R8
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |-> (active == '0));

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        // R6
        win_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (query_valid && active[g]) |->
            cfg_prio[g*PRIO_W +: PRIO_W] <= cfg_prio[query_id*PRIO_W +: PRIO_W]);
        // R7
        tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (query_valid && active[g] && (ID_W'(g) < query_id)) |->
            cfg_prio[g*PRIO_W +: PRIO_W] < cfg_prio[query_id*PRIO_W +: PRIO_W]);
    end
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_line = '0, cfg_enable = '1, cfg_edge = '0, cfg_falling = '0;
    logic [31:0] cfg_prio = 32'h4905_F177;   // src0..7 = 7? see below
    logic       clr_valid = 1'b0;
    logic [2:0] clr_index = '0;
    logic       irq_out, query_valid;
    logic [2:0] query_id;
    int checks = 0, fails = 0;

    // priorities: src0=3 src1=7 src2=7 src3=1 src4=15 src5=0 src6=9 src7=4
    localparam logic [31:0] PRIO = {4'd4, 4'd9, 4'd0, 4'd15, 4'd1, 4'd7, 4'd7, 4'd3};

    // {lines, exp_valid, exp_id}
    localparam logic [11:0] VEC [8] = '{
        {8'h00, 1'b0, 3'd0}, {8'h01, 1'b1, 3'd0}, {8'h06, 1'b1, 3'd1},
        {8'h46, 1'b1, 3'd6}, {8'hFF, 1'b1, 3'd4}, {8'h20, 1'b1, 3'd5},
        {8'h88, 1'b1, 3'd7}, {8'h09, 1'b1, 3'd0}};

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .cfg_enable(cfg_enable),
        .cfg_edge(cfg_edge), .cfg_falling(cfg_falling), .cfg_prio(cfg_prio),
        .clr_valid(clr_valid), .clr_index(clr_index), .irq_out(irq_out),
        .query_valid(query_valid), .query_id(query_id));

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_src(input int idx);
        clr_valid = 1'b1;
        clr_index = 3'(idx);
        tick(1);
        clr_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails + 0);
        $finish;
    end

    initial begin
        cfg_prio = PRIO;
        tick(3);
        // reset state, R8 and R5
        chk("R8 reset valid", query_valid, 0);
        chk("R5 reset irq", irq_out, 0);
        rst_n = 1'b1;
        tick(2);

        // level-mode table, R1 R5 R6 R7 R8
        for (int k = 0; k < 8; k++) begin
            irq_line = VEC[k][11:4];
            tick(3);
            chk("R8/R1 table valid", query_valid, VEC[k][3]);
            chk("R5 table irq", irq_out, VEC[k][3]);
            if (VEC[k][3]) chk("R6/R7 table id", query_id, VEC[k][2:0]);
        end

        // R10 level latency and R1 withdrawal
        irq_line = '0;
        tick(3);
        irq_line[0] = 1'b1;
        tick(1);
        chk("R10 level not yet", query_valid, 0);
        tick(1);
        chk("R10 level after 2", query_valid, 1);
        irq_line[0] = 1'b0;
        tick(2);
        chk("R1 level withdrawn", query_valid, 0);

        // switch to edge mode: 2,3,4,6 edge; 3 falling; 4 disabled
        cfg_edge = 8'b0101_1100;
        cfg_falling = 8'b0000_1000;
        cfg_enable = 8'b1110_1111;
        tick(4);

        // R2 R10 rising capture
        irq_line[2] = 1'b1;
        tick(2);
        chk("R10 edge not yet", query_valid, 0);
        tick(1);
        chk("R10 edge after 3", query_valid, 1);
        chk("R2 edge id", query_id, 2);
        irq_line[2] = 1'b0;
        tick(4);
        chk("R2 sticky", query_valid, 1);
        irq_line[2] = 1'b1; tick(2); irq_line[2] = 1'b0; tick(4);
        chk("R4 line no clear", query_valid, 1);
        clear_src(2);
        chk("R4 R10 cleared", query_valid, 0);
        chk("R5 irq after clear", irq_out, 0);

        // R3 falling only
        irq_line[3] = 1'b1;
        tick(4);
        chk("R3 rise ignored", query_valid, 0);
        irq_line[3] = 1'b0;
        tick(4);
        chk("R3 fall captured", query_valid, 1);
        chk("R3 fall id", query_id, 3);

        // R4 clear and new edge in same cycle
        irq_line[3] = 1'b1;
        tick(4);
        irq_line[3] = 1'b0;
        tick(2);
        clear_src(3);
        chk("R4 same-cycle edge kept", query_valid, 1);
        clear_src(3);
        chk("R4 plain clear", query_valid, 0);

        // R9 disabled source records edge
        irq_line[4] = 1'b1; tick(3); irq_line[4] = 1'b0; tick(4);
        chk("R9 disabled no query", query_valid, 0);
        chk("R9 disabled no irq", irq_out, 0);
        cfg_enable[4] = 1'b1;
        #1;
        chk("R9 enabled shows", query_valid, 1);
        chk("R9 enabled id", query_id, 4);
        tick(1);
        clear_src(4);

        // R6 next-highest after clear
        irq_line[2] = 1'b1; irq_line[6] = 1'b1;
        tick(3);
        irq_line[2] = 1'b0; irq_line[6] = 1'b0;
        tick(3);
        chk("R6 highest first", query_id, 6);
        clear_src(6);
        chk("R6 next highest", query_id, 2);
        chk("R6 still valid", query_valid, 1);
        clear_src(2);
        chk("R8 none left", query_valid, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule